// File: doc/BRIEF.md
# Pipelined Converter Capture Front End

This block sits between a free-running 16-bit pipelined analog-to-digital converter and the sample path of an acquisition system. The converter takes a new sample on every rising edge of its clock and needs no separate convert strobe. Its results emerge only after a fixed pipeline delay. The block gates the converter clock with an enable. It counts the clocks since the acquisition controller issued a start, and it marks a captured word as valid only once real conversion results have reached the data pins. The pins are single-ended CMOS, so the block registers them directly.

The converter can present its results either in straight offset binary or in two's complement. A run-time coding input tells the block which coding goes with each word, and the block always hands two's complement downstream. Each word passes through exactly two registers: one at the pins and one after format normalisation. The downstream interface is a valid flag plus a data word. Once the pipeline has filled, the flag stays high on every clock until a stop pulse or a reset.

Top module: `adc_capture_frontend`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `conv_clk_en` low, `sample_valid` low and `sample_data` equal to 0x0000 after that edge. A later start goes through the full pipeline fill again.
- R2: After an edge where `start` is high and `stop` is low, `conv_clk_en` is high. It stays high until a stop or a reset, and it is low before the first start.
- R3: Call the start edge edge 0. The words on `adc_data_in` at edges 1 through 12 are discarded. The word present at edge 13 is the first word delivered with `sample_valid` high, which happens after edge 14.
- R4: After the fill, `sample_valid` is high after every edge while the capture is running, with no gaps.
- R5: A word present on `adc_data_in` at edge n appears on `sample_data` after edge n+1, which is a latency of two clocks.
- R6: When `coding_sel` is 0 (two's complement), the word is passed through with every bit unchanged.
- R7: When `coding_sel` is 1 (offset binary), the output equals the input plus 0x8000 modulo 2^16. This means bit 15 is inverted and bits 14..0 are kept, so 0x8000 becomes 0x0000, 0x0000 becomes 0x8000 and 0xFFFF becomes 0x7FFF.
- R8: `coding_sel` is sampled together with the data word at the same edge. Changing it between consecutive words applies the new coding to those words only.
- R9: A start pulse while a capture is running restarts the fill. `sample_valid` is low after the start edge and stays low until edge 14 counted from the new start.
- R10: After an edge where `stop` is high, `conv_clk_en` and `sample_valid` are both low. When `start` and `stop` are high together, stop takes priority and the block stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one converter sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins or restarts a capture |
| stop | input | 1 | One-cycle pulse that ends a capture; takes priority over start |
| coding_sel | input | 1 | Coding of the word on the pins: 0 two's complement, 1 offset binary |
| adc_data_in | input | 16 | Parallel converter output word |
| conv_clk_en | output | 1 | Enable for the converter clock |
| sample_valid | output | 1 | Sample on `sample_data` holds a real conversion result |
| sample_data | output | 16 | Captured sample in two's complement |

## Verification
The bench numbers every edge relative to the most recent start. It keeps the last two driven words with their coding, because a word driven at edge n must appear after edge n+1, while the valid flag follows the rule "high after edge n only when n is at least 14". The clock enable is due one edge after start or stop, and so is the drop of the valid flag on stop or restart. The bench samples all outputs one nanosecond after each rising edge, compares them with the values that edge count predicts, and drives the next inputs at the same point. The expected normalised value is computed by modular addition of 0x8000, not by bit inversion.

// File: rtl/adc_cap_pkg.sv
`timescale 1ns/1ps
package adc_cap_pkg;
  localparam int unsigned SAMPLE_W_DEF  = 16;
  localparam int unsigned FILL_CLKS_DEF = 13;

  typedef enum logic {
    CODE_TWOS   = 1'b0,
    CODE_OFFSET = 1'b1
  } coding_e;
endpackage

// File: rtl/adc_fill_tracker.sv
`timescale 1ns/1ps
module adc_fill_tracker #(
  parameter int unsigned FILL_CLKS = 13,
  parameter int unsigned CNT_W     = ($clog2(FILL_CLKS) < 1) ? 1 : $clog2(FILL_CLKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic conv_en,
  output logic pin_vld
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FILL_CLKS - 1);

  logic             running;
  logic [CNT_W-1:0] fill_cnt;
  logic             fill_done;
  logic             clear_evt;

  assign fill_done = (fill_cnt == LAST_CNT);
  assign clear_evt = start | stop;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
    end
  end

  // Converter clocks seen since start, saturating at the last fill clock
  always_ff @(posedge clk) begin
    if (rst || clear_evt) begin
      fill_cnt <= '0;
    end else if (running && !fill_done) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  // Word being captured at the pins now is a real result
  always_ff @(posedge clk) begin
    if (rst || clear_evt) begin
      pin_vld <= 1'b0;
    end else begin
      pin_vld <= running && fill_done;
    end
  end

  assign conv_en = running;

  a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> conv_en);
  a_r10_stop_halts: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!conv_en && !pin_vld));
  a_r9_restart_blanks: assert property (@(posedge clk) disable iff (rst)
    start |=> !pin_vld);
  a_r4_valid_needs_run: assert property (@(posedge clk) disable iff (rst)
    pin_vld |-> conv_en);
endmodule

// File: rtl/adc_pin_stage.sv
`timescale 1ns/1ps
module adc_pin_stage #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] pin_data,
  input  logic                pin_mode,
  output logic [SAMPLE_W-1:0] cap_data,
  output logic                cap_mode
);
  // First register, right at the converter pins; coding travels with the word
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data <= '0;
      cap_mode <= 1'b0;
    end else begin
      cap_data <= pin_data;
      cap_mode <= pin_mode;
    end
  end

  a_r8_mode_with_word: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cap_mode == $past(pin_mode) && cap_data == $past(pin_data)));
endmodule

// File: rtl/adc_fmt_stage.sv
`timescale 1ns/1ps
module adc_fmt_stage #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_mode,
  input  logic                in_vld,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_vld
);
  import adc_cap_pkg::*;

  localparam logic [SAMPLE_W-1:0] SIGN_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};

  function automatic logic [SAMPLE_W-1:0] to_signed_word(
    input logic [SAMPLE_W-1:0] w, input coding_e code);
    return (code == CODE_OFFSET) ? (w ^ SIGN_MASK) : w;
  endfunction

  logic [SAMPLE_W-1:0] norm_word;
  assign norm_word = to_signed_word(in_data, coding_e'(in_mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
    end else begin
      out_data <= norm_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  a_r6_twos_passthru: assert property (@(posedge clk) disable iff (rst)
    !in_mode |=> (out_data == $past(in_data)));
  a_r7_offset_msb_flip: assert property (@(posedge clk) disable iff (rst)
    in_mode |=> (out_data[SAMPLE_W-1] != $past(in_data[SAMPLE_W-1]) &&
                 out_data[SAMPLE_W-2:0] == $past(in_data[SAMPLE_W-2:0])));
endmodule

// File: rtl/adc_capture_frontend.sv
`timescale 1ns/1ps
module adc_capture_frontend #(
  parameter int unsigned SAMPLE_W  = adc_cap_pkg::SAMPLE_W_DEF,
  parameter int unsigned FILL_CLKS = adc_cap_pkg::FILL_CLKS_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                stop,
  input  logic                coding_sel,
  input  logic [SAMPLE_W-1:0] adc_data_in,
  output logic                conv_clk_en,
  output logic                sample_valid,
  output logic [SAMPLE_W-1:0] sample_data
);
  logic                pin_vld;
  logic [SAMPLE_W-1:0] cap_data;
  logic                cap_mode;
  logic                restart_or_stop;

  assign restart_or_stop = start | stop;

  adc_fill_tracker #(
    .FILL_CLKS (FILL_CLKS)
  ) u_fill (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stop    (stop),
    .conv_en (conv_clk_en),
    .pin_vld (pin_vld)
  );

  adc_pin_stage #(
    .SAMPLE_W (SAMPLE_W)
  ) u_pin (
    .clk      (clk),
    .rst      (rst),
    .pin_data (adc_data_in),
    .pin_mode (coding_sel),
    .cap_data (cap_data),
    .cap_mode (cap_mode)
  );

  adc_fmt_stage #(
    .SAMPLE_W (SAMPLE_W)
  ) u_fmt (
    .clk      (clk),
    .rst      (rst),
    .clr      (restart_or_stop),
    .in_data  (cap_data),
    .in_mode  (cap_mode),
    .in_vld   (pin_vld),
    .out_data (sample_data),
    .out_vld  (sample_valid)
  );

  a_r4_valid_from_pins: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(pin_vld));
  a_r4_valid_only_running: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> conv_clk_en);
  a_r10_stop_drops_valid: assert property (@(posedge clk) disable iff (rst)
    stop |=> !sample_valid);
endmodule

// File: tb/adc_capture_frontend_tb.sv
`timescale 1ns/1ps
module adc_capture_frontend_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        coding_sel = 1'b0;
  logic [15:0] adc_data_in = 16'h0000;
  logic        conv_clk_en;
  logic        sample_valid;
  logic [15:0] sample_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  int          e = 0;
  bit          run_b = 0;
  bit          restarted = 0;
  logic [15:0] h1_d = 0, h2_d = 0;
  bit          h1_m = 0, h2_m = 0, h3_m = 0;

  always #2 clk = ~clk;

  adc_capture_frontend u_dut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .stop         (stop),
    .coding_sel   (coding_sel),
    .adc_data_in  (adc_data_in),
    .conv_clk_en  (conv_clk_en),
    .sample_valid (sample_valid),
    .sample_data  (sample_data)
  );

  function automatic logic [15:0] expect_word(logic [15:0] w, bit offset);
    int unsigned v;
    v = offset ? ((int'(w) + 32768) % 65536) : int'(w);
    return v[15:0];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [15:0] d, input bit m, input bit st, input bit sp);
    bit    exp_v;
    string vtag;
    string dtag;
    adc_data_in = d;
    coding_sel  = m;
    start       = st;
    stop        = sp;
    @(posedge clk);
    #1;
    start = 0;
    stop  = 0;
    h3_m = h2_m; h2_m = h1_m; h2_d = h1_d; h1_m = m; h1_d = d;
    if (sp) begin
      run_b = 0;
    end else if (st) begin
      restarted = run_b;
      run_b = 1;
      e = 0;
    end else if (run_b) begin
      e++;
    end
    check(conv_clk_en == run_b, sp ? "R10" : "R2", conv_clk_en, run_b);
    exp_v = run_b && (e >= 14);
    if (sp) vtag = "R10";
    else if (restarted && e < 14) vtag = "R9";
    else if (e <= 14) vtag = "R3";
    else vtag = "R4";
    check(sample_valid == exp_v, vtag, sample_valid, exp_v);
    if (exp_v) begin
      if (e == 20) dtag = "R5";
      else if (h2_m != h3_m) dtag = "R8";
      else if (h2_m) dtag = "R7";
      else dtag = "R6";
      check(sample_data == expect_word(h2_d, h2_m), dtag, sample_data,
            expect_word(h2_d, h2_m));
    end
  endtask

  task automatic do_reset(input int n);
    rst = 1;
    start = 0;
    stop = 0;
    repeat (n) @(posedge clk);
    #1;
    rst = 0;
    run_b = 0; restarted = 0; e = 0;
    h1_d = 0; h2_d = 0; h1_m = 0; h2_m = 0; h3_m = 0;
    check(conv_clk_en == 1'b0, "R1", conv_clk_en, 0);
    check(sample_valid == 1'b0, "R1", sample_valid, 0);
    check(sample_data == 16'h0000, "R1", sample_data, 0);
  endtask

  function automatic logic [15:0] pattern(int k);
    case (k)
      20: return 16'h0000;
      21: return 16'h7FFF;
      22: return 16'h8000;
      23: return 16'hFFFF;
      default: return 16'(k * 16'h0B3D + 16'h7FF0);
    endcase
  endfunction

  initial begin
    adc_data_in = 16'hDEAD;
    coding_sel  = 1;
    do_reset(3);
    // R2: no enable or valid before any start
    for (int k = 0; k < 5; k++) cyc(16'hA5A5, 0, 0, 0);
    // first capture: corner words and coding changes every four words
    cyc(16'h1111, 0, 1, 0);
    for (int k = 1; k < 60; k++) cyc(pattern(k), bit'((k / 4) % 2), 0, 0);
    // R9: restart while running
    cyc(16'h2222, 1, 1, 0);
    for (int k = 1; k < 30; k++) cyc(pattern(k + 7), bit'(k % 2), 0, 0);
    // R10: stop, then idle
    cyc(16'h3333, 0, 0, 1);
    for (int k = 0; k < 5; k++) cyc(16'h4444, 0, 0, 0);
    // R10: start and stop together stays stopped
    cyc(16'h5555, 0, 1, 1);
    for (int k = 0; k < 5; k++) cyc(16'h6666, 1, 0, 0);
    // sweep of words against both codings
    cyc(16'h0001, 0, 1, 0);
    for (int k = 1; k < 14 + 512; k++)
      cyc(16'((k * 16'h0101) ^ (k << 7)), bit'(k[0] ^ k[5]), 0, 0);
    // R1: reset in the middle of a run, then refill from scratch
    do_reset(2);
    for (int k = 0; k < 5; k++) cyc(16'h7777, 0, 0, 0);
    cyc(16'h8888, 1, 1, 0);
    for (int k = 1; k < 24; k++) cyc(pattern(k + 3), 1, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule